// File: doc/BRIEF.md
# Span Z and Colour Interpolator

This block walks one horizontal span of pixels for a 3D rendering pipeline. The host presents a start pulse along with a setup record: a starting Z with its per-pixel slope, starting red, green and blue levels with their slopes, a signed pixel count, a 24-bit frame-buffer address and a control record. The control record holds the compare selection, the interpolation holds, pseudo-colour mode, the depth-precision choice and the screen-door pattern. The block captures the whole record when it accepts the start pulse. It then produces one pixel per clock.

For each pixel, the block presents the pixel address on `rd_addr`. The frame-buffer side returns the stored depth on `old_z` in the same cycle. The block compares the stored depth with the pixel's own Z and registers the pixel address, the colour, the Z integer and the two write enables. After that it adds the slopes to its running values. The depth word format changes at run time between a 16.12 layout and a 24.12 layout.

The sequencer has three states. **IDLE** waits for work. **WALK** issues one pixel per cycle. **FLUSH** holds `busy` high for the cycle in which the last pixel is on the outputs. The transitions are:
- **IDLE→WALK** on an accepted start.
- **WALK→WALK** while more than one pixel remains.
- **WALK→FLUSH** when the pixel being issued is the last one.
- **FLUSH→IDLE** unconditionally.

Top module: `span_interp`

## Requirements
- R1: A start pulse is accepted only in IDLE, and only when `span_count`, read as a 13-bit two's-complement number, is greater than zero. A count of zero or below produces no pixel, and `busy` stays low.
- R2: If a start is accepted at clock edge E, then:
  - `busy` is high from E until the edge after the last pixel's valid cycle.
  - Pixel k (counting from 0) is on the outputs with `pix_valid` high in the cycle after edge E+1+k.
  - Exactly N consecutive valid cycles occur for a count of N.
- R3: A start pulse that arrives while `busy` is high has no effect. The running span keeps its length, and no extra pixels follow it.
- R4: When `cfg_z_wide`=0, Z and its slope are taken from bits [31:4] of `z_main` and `dz_main` as 16.12 values. `z_ext`, `dz_ext` and bits [3:0] of the main words are ignored. The running Z wraps modulo 2^28.
- R5: When `cfg_z_wide`=1, Z and its slope are 24.12 values. The upper 32 bits come from the main word, and the low 4 fraction bits come from bits [31:28] of the extension word. The running Z wraps modulo 2^36, and a slope with its top bit set acts as a negative step.
- R6: `pix_z` is the integer part of the pixel's Z. `cfg_cmp` bit 2 enables "new < old", bit 1 enables "new > old" and bit 0 enables "new == old", all compared unsigned against `old_z`. `pix_z_we` is high only when an enabled condition holds.
- R7: Each colour level and slope is a 20-bit 8.12 value, with the slope in two's complement. Pixel k shows the integer part of the start value after k slope additions.
- R8: After each addition, a colour level below 0 becomes 0.000 and a level above 255.FFF becomes 255.FFF (all ones).
- R9: With `cfg_pseudo`=1, `pix_red` and `pix_green` are 0 on every pixel, and only blue is interpolated.
- R10: `cfg_z_hold`=1 keeps Z at its start value for the whole span. `cfg_c_hold`=1 does the same for all three colours.
- R11: `pix_addr` starts at `gfx_addr` and increments by 1 per pixel, modulo 2^24. With `cfg_addr_hold`=1 it stays at `gfx_addr`.
- R12: For pixel k, bit (k mod 16) of `cfg_mask` is the screen-door bit. If that bit is 0, both `pix_c_we` and `pix_z_we` are 0. If it is 1, `pix_c_we` is 1 and `pix_z_we` follows R6. Both enables are 0 whenever `pix_valid` is 0.
- R13: After reset, `busy`, `pix_valid`, `pix_z_we` and `pix_c_we` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a span (one-cycle pulse) |
| span_count | input | 13 | Signed pixel count |
| gfx_addr | input | 24 | Address of the first pixel |
| cfg_mask | input | 16 | Screen-door pattern |
| cfg_z_hold | input | 1 | Hold Z constant |
| cfg_c_hold | input | 1 | Hold colours constant |
| cfg_addr_hold | input | 1 | Do not step the address |
| cfg_pseudo | input | 1 | Pseudo-colour: blue only |
| cfg_z_wide | input | 1 | 1 = 24.12 Z, 0 = 16.12 Z |
| cfg_cmp | input | 3 | Compare enables {lt, gt, eq} |
| z_main | input | 32 | Start Z, main word |
| z_ext | input | 32 | Start Z, extension word |
| dz_main | input | 32 | Z slope, main word |
| dz_ext | input | 32 | Z slope, extension word |
| red_init | input | 20 | Red start, 8.12 |
| green_init | input | 20 | Green start, 8.12 |
| blue_init | input | 20 | Blue start, 8.12 |
| red_step | input | 20 | Red slope, signed 8.12 |
| green_step | input | 20 | Green slope, signed 8.12 |
| blue_step | input | 20 | Blue slope, signed 8.12 |
| rd_addr | output | 24 | Address of the pixel being issued |
| old_z | input | 24 | Stored depth at `rd_addr`, same cycle |
| busy | output | 1 | Span in progress |
| pix_valid | output | 1 | Pixel outputs are valid |
| pix_addr | output | 24 | Pixel address |
| pix_red | output | 8 | Red integer |
| pix_green | output | 8 | Green integer |
| pix_blue | output | 8 | Blue integer |
| pix_z | output | 24 | Z integer |
| pix_z_we | output | 1 | Depth write enable |
| pix_c_we | output | 1 | Colour write enable |

## Verification
The hardest situations to reach are a start pulse that lands in WALK or FLUSH, and the two wrap points. The first wrap point is the 16.12 Z rolling over at 2^28 while the address rolls over at 2^24. The second is the screen-door index cycling past 15 on a long span.

The bench drives a second start with a different count partway through a span, and checks that the pixel stream keeps its original length. It starts a 16-bit span just below the top of both the Z range and the address range, and runs a 300-pixel span with an irregular mask. Because the stored depth is made equal to the pixel address, the Z compare can be steered through less-than, equal and greater-than on chosen pixels.

// File: rtl/span_pkg.sv
package span_pkg;

    localparam int MASK_W  = 16;
    localparam int MASK_IW = $clog2(MASK_W);

    localparam int CMP_EQ = 0;
    localparam int CMP_GT = 1;
    localparam int CMP_LT = 2;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WALK  = 2'd1,
        ST_FLUSH = 2'd2
    } span_state_e;

    typedef struct packed {
        logic [MASK_W-1:0] door;
        logic              z_hold;
        logic              c_hold;
        logic              a_hold;
        logic              pseudo;
        logic [2:0]        cmp;
    } span_cfg_t;

endpackage

// File: rtl/span_ctrl.sv
module span_ctrl
    import span_pkg::*;
#(
    parameter int CNT_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [CNT_W-1:0] count,
    output logic             accept,
    output logic             advance,
    output logic             busy
);

    localparam int REM_W = CNT_W - 1;

    span_state_e      state_q, state_d;
    logic [REM_W-1:0] remain_q;

    // a start is taken only when idle and the signed count is positive
    always_comb begin
        accept = (state_q == ST_IDLE) && start
                 && !count[CNT_W-1] && (count != '0);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_WALK;
            ST_WALK:  if (remain_q == REM_W'(1)) state_d = ST_FLUSH;
            ST_FLUSH: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            remain_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept)
                remain_q <= count[REM_W-1:0];
            else if (state_q == ST_WALK)
                remain_q <= remain_q - 1'b1;
        end
    end

    always_comb begin
        advance = (state_q == ST_WALK);
        busy    = (state_q != ST_IDLE);
    end

endmodule

// File: rtl/span_z_unit.sv
module span_z_unit
    import span_pkg::*;
#(
    parameter int WORD = 32,
    parameter int ZI   = 24,
    parameter int ZF   = 12,
    parameter int NI   = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            advance,
    input  logic            wide_in,
    input  logic            hold,
    input  logic [2:0]      cmp,
    input  logic [WORD-1:0] z_main,
    input  logic [WORD-1:0] z_ext,
    input  logic [WORD-1:0] dz_main,
    input  logic [WORD-1:0] dz_ext,
    input  logic [ZI-1:0]   old_z,
    output logic [ZI-1:0]   z_int,
    output logic            pass
);

    localparam int ZW   = ZI + ZF;
    localparam int XF   = ZW - WORD;
    localparam int NW   = NI + ZF;
    localparam int NPAD = ZW - NW;

    logic [ZW-1:0] z_q, dz_q, z_sum, z_next;
    logic          wide_q;

    logic unused_bits;
    assign unused_bits = ^{z_ext[WORD-XF-1:0], dz_ext[WORD-XF-1:0]};

    function automatic logic [ZW-1:0] unpack_z(input logic wide,
                                               input logic [WORD-1:0] m,
                                               input logic [WORD-1:0] e);
        if (wide)
            return {m, e[WORD-1 -: XF]};
        else
            return {{NPAD{1'b0}}, m[WORD-1 -: NW]};
    endfunction

    always_comb begin
        z_sum  = z_q + dz_q;
        z_next = wide_q ? z_sum : {{NPAD{1'b0}}, z_sum[NW-1:0]};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            z_q    <= '0;
            dz_q   <= '0;
            wide_q <= 1'b0;
        end else if (load) begin
            z_q    <= unpack_z(wide_in, z_main, z_ext);
            dz_q   <= unpack_z(wide_in, dz_main, dz_ext);
            wide_q <= wide_in;
        end else if (advance && !hold) begin
            z_q <= z_next;
        end
    end

    always_comb begin
        z_int = z_q[ZW-1:ZF];
        pass  = (cmp[CMP_LT] && (z_int <  old_z))
              | (cmp[CMP_GT] && (z_int >  old_z))
              | (cmp[CMP_EQ] && (z_int == old_z));
    end

endmodule

// File: rtl/span_color_chan.sv
module span_color_chan #(
    parameter int CI = 8,
    parameter int CF = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             advance,
    input  logic             hold,
    input  logic             blank,
    input  logic [CI+CF-1:0] start_v,
    input  logic [CI+CF-1:0] slope_v,
    output logic [CI-1:0]    level
);

    localparam int CW = CI + CF;
    localparam int EW = CW + 2;

    logic [CW-1:0] c_q, s_q, c_next;
    logic [EW-1:0] ext_sum;

    always_comb begin
        ext_sum = {2'b00, c_q} + {{2{s_q[CW-1]}}, s_q};
        if (ext_sum[EW-1])
            c_next = '0;
        else if (ext_sum[EW-2])
            c_next = '1;
        else
            c_next = ext_sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q <= '0;
            s_q <= '0;
        end else if (load) begin
            c_q <= start_v;
            s_q <= slope_v;
        end else if (advance && !hold) begin
            c_q <= c_next;
        end
    end

    assign level = blank ? '0 : c_q[CW-1:CF];

endmodule

// File: rtl/span_interp.sv
module span_interp
    import span_pkg::*;
#(
    parameter int AW    = 24,
    parameter int CNT_W = 13,
    parameter int WORD  = 32,
    parameter int ZI    = 24,
    parameter int ZF    = 12,
    parameter int NI    = 16,
    parameter int CI    = 8,
    parameter int CF    = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  span_count,
    input  logic [AW-1:0]     gfx_addr,
    input  logic [MASK_W-1:0] cfg_mask,
    input  logic              cfg_z_hold,
    input  logic              cfg_c_hold,
    input  logic              cfg_addr_hold,
    input  logic              cfg_pseudo,
    input  logic              cfg_z_wide,
    input  logic [2:0]        cfg_cmp,
    input  logic [WORD-1:0]   z_main,
    input  logic [WORD-1:0]   z_ext,
    input  logic [WORD-1:0]   dz_main,
    input  logic [WORD-1:0]   dz_ext,
    input  logic [CI+CF-1:0]  red_init,
    input  logic [CI+CF-1:0]  green_init,
    input  logic [CI+CF-1:0]  blue_init,
    input  logic [CI+CF-1:0]  red_step,
    input  logic [CI+CF-1:0]  green_step,
    input  logic [CI+CF-1:0]  blue_step,
    output logic [AW-1:0]     rd_addr,
    input  logic [ZI-1:0]     old_z,
    output logic              busy,
    output logic              pix_valid,
    output logic [AW-1:0]     pix_addr,
    output logic [CI-1:0]     pix_red,
    output logic [CI-1:0]     pix_green,
    output logic [CI-1:0]     pix_blue,
    output logic [ZI-1:0]     pix_z,
    output logic              pix_z_we,
    output logic              pix_c_we
);

    localparam int CW  = CI + CF;
    localparam int NCH = 3;

    logic                        accept, advance;
    span_cfg_t                   cfg_q;
    logic [AW-1:0]               addr_q;
    logic [MASK_IW-1:0]          idx_q;
    logic [ZI-1:0]               z_int;
    logic                        z_pass;
    logic [NCH-1:0][CW-1:0]      c_start, c_slope;
    logic [NCH-1:0][CI-1:0]      c_level;

    assign c_start = {blue_init, green_init, red_init};
    assign c_slope = {blue_step, green_step, red_step};

    span_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .count   (span_count),
        .accept  (accept),
        .advance (advance),
        .busy    (busy)
    );

    span_z_unit #(.WORD(WORD), .ZI(ZI), .ZF(ZF), .NI(NI)) u_z (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (accept),
        .advance (advance),
        .wide_in (cfg_z_wide),
        .hold    (cfg_q.z_hold),
        .cmp     (cfg_q.cmp),
        .z_main  (z_main),
        .z_ext   (z_ext),
        .dz_main (dz_main),
        .dz_ext  (dz_ext),
        .old_z   (old_z),
        .z_int   (z_int),
        .pass    (z_pass)
    );

    // channel 0 = red, 1 = green, 2 = blue; only the last survives pseudo mode
    for (genvar ch = 0; ch < NCH; ch++) begin : g_chan
        localparam bit MAY_BLANK = (ch != NCH - 1);
        span_color_chan #(.CI(CI), .CF(CF)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (accept),
            .advance (advance),
            .hold    (cfg_q.c_hold),
            .blank   (MAY_BLANK && cfg_q.pseudo),
            .start_v (c_start[ch]),
            .slope_v (c_slope[ch]),
            .level   (c_level[ch])
        );
    end

    // span context captured on acceptance
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            addr_q <= '0;
            idx_q  <= '0;
        end else if (accept) begin
            cfg_q.door   <= cfg_mask;
            cfg_q.z_hold <= cfg_z_hold;
            cfg_q.c_hold <= cfg_c_hold;
            cfg_q.a_hold <= cfg_addr_hold;
            cfg_q.pseudo <= cfg_pseudo;
            cfg_q.cmp    <= cfg_cmp;
            addr_q       <= gfx_addr;
            idx_q        <= '0;
        end else if (advance) begin
            if (!cfg_q.a_hold)
                addr_q <= addr_q + 1'b1;
            idx_q <= idx_q + 1'b1;
        end
    end

    assign rd_addr = addr_q;

    // pixel output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pix_valid <= 1'b0;
            pix_addr  <= '0;
            pix_red   <= '0;
            pix_green <= '0;
            pix_blue  <= '0;
            pix_z     <= '0;
            pix_z_we  <= 1'b0;
            pix_c_we  <= 1'b0;
        end else begin
            pix_valid <= advance;
            if (advance) begin
                pix_addr  <= addr_q;
                pix_red   <= c_level[0];
                pix_green <= c_level[1];
                pix_blue  <= c_level[2];
                pix_z     <= z_int;
                pix_c_we  <= cfg_q.door[idx_q];
                pix_z_we  <= cfg_q.door[idx_q] & z_pass;
            end else begin
                pix_c_we <= 1'b0;
                pix_z_we <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/span_interp_chk.sv
module span_interp_chk #(
    parameter int AW = 24,
    parameter int CI = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          busy,
    input logic          pix_valid,
    input logic          pix_z_we,
    input logic          pix_c_we,
    input logic [AW-1:0] pix_addr,
    input logic [CI-1:0] pix_red,
    input logic [CI-1:0] pix_green,
    input logic          pseudo_q,
    input logic          a_hold_q
);

    a_r2_valid_inside_busy: assert property (@(posedge clk) disable iff (!rst_n)
        pix_valid |-> busy);

    a_r1_busy_needs_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    a_r2_last_pixel_before_idle: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(pix_valid));

    a_r12_door_gates_both: assert property (@(posedge clk) disable iff (!rst_n)
        pix_z_we |-> pix_c_we);

    a_r12_enables_need_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_z_we || pix_c_we) |-> pix_valid);

    a_r9_pseudo_blanks: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && pseudo_q) |-> (pix_red == '0 && pix_green == '0));

    a_r11_addr_steps: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && !a_hold_q)
            |-> ((pix_addr - $past(pix_addr)) == AW'(1)));

    a_r11_addr_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_valid && $past(pix_valid) && a_hold_q) |-> $stable(pix_addr));

endmodule

bind span_interp span_interp_chk #(.AW(AW), .CI(CI)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .pix_valid (pix_valid),
    .pix_z_we  (pix_z_we),
    .pix_c_we  (pix_c_we),
    .pix_addr  (pix_addr),
    .pix_red   (pix_red),
    .pix_green (pix_green),
    .pseudo_q  (cfg_q.pseudo),
    .a_hold_q  (cfg_q.a_hold)
);

// File: tb/span_interp_test.sv
`timescale 1ns/1ps
module span_interp_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [12:0] span_count = '0;
    logic [23:0] gfx_addr = '0;
    logic [15:0] cfg_mask = 16'hFFFF;
    logic        cfg_z_hold = 0, cfg_c_hold = 0, cfg_addr_hold = 0;
    logic        cfg_pseudo = 0, cfg_z_wide = 0;
    logic [2:0]  cfg_cmp = 3'b100;
    logic [31:0] z_main = '0, z_ext = '0, dz_main = '0, dz_ext = '0;
    logic [19:0] red_init = '0, green_init = '0, blue_init = '0;
    logic [19:0] red_step = '0, green_step = '0, blue_step = '0;
    logic [23:0] rd_addr, old_z;
    logic        busy, pix_valid, pix_z_we, pix_c_we;
    logic [23:0] pix_addr, pix_z;
    logic [7:0]  pix_red, pix_green, pix_blue;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    // the stored depth of each location equals its address
    assign old_z = rd_addr;

    span_interp uut (
        .clk(clk), .rst_n(rst_n), .start(start), .span_count(span_count),
        .gfx_addr(gfx_addr), .cfg_mask(cfg_mask), .cfg_z_hold(cfg_z_hold),
        .cfg_c_hold(cfg_c_hold), .cfg_addr_hold(cfg_addr_hold),
        .cfg_pseudo(cfg_pseudo), .cfg_z_wide(cfg_z_wide), .cfg_cmp(cfg_cmp),
        .z_main(z_main), .z_ext(z_ext), .dz_main(dz_main), .dz_ext(dz_ext),
        .red_init(red_init), .green_init(green_init), .blue_init(blue_init),
        .red_step(red_step), .green_step(green_step), .blue_step(blue_step),
        .rd_addr(rd_addr), .old_z(old_z), .busy(busy), .pix_valid(pix_valid),
        .pix_addr(pix_addr), .pix_red(pix_red), .pix_green(pix_green),
        .pix_blue(pix_blue), .pix_z(pix_z), .pix_z_we(pix_z_we), .pix_c_we(pix_c_we)
    );

    task automatic check(input bit ok, input string tag, input string what);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s", tag, what);
        end
    endtask

    // expected pixel stream
    int e_addr[$], e_z[$], e_r[$], e_g[$], e_b[$], e_zwe[$], e_cwe[$];

    function automatic int to_signed20(input logic [19:0] v);
        int s = int'(v);
        if (v[19]) s -= (1 << 20);
        return s;
    endfunction

    task automatic build_model(input int n);
        longint zv, dzv, zmask;
        int cv[3], sv[3];
        int a;
        e_addr.delete(); e_z.delete(); e_r.delete(); e_g.delete();
        e_b.delete(); e_zwe.delete(); e_cwe.delete();
        if (cfg_z_wide) begin
            zv    = longint'({z_main, z_ext[31:28]});
            dzv   = longint'({dz_main, dz_ext[31:28]});
            zmask = (longint'(1) << 36) - 1;
        end else begin
            zv    = longint'(z_main[31:4]);
            dzv   = longint'(dz_main[31:4]);
            zmask = (longint'(1) << 28) - 1;
        end
        cv[0] = int'(red_init);  cv[1] = int'(green_init);  cv[2] = int'(blue_init);
        sv[0] = to_signed20(red_step);
        sv[1] = to_signed20(green_step);
        sv[2] = to_signed20(blue_step);
        for (int k = 0; k < n; k++) begin
            int zi;
            bit pass, door;
            a  = cfg_addr_hold ? int'(gfx_addr) : ((int'(gfx_addr) + k) & 24'hFFFFFF);
            zi = int'(zv >> 12);
            pass = (cfg_cmp[2] && zi < a) || (cfg_cmp[1] && zi > a) || (cfg_cmp[0] && zi == a);
            door = cfg_mask[k % 16];
            e_addr.push_back(a);
            e_z.push_back(zi);
            e_r.push_back(cfg_pseudo ? 0 : (cv[0] >> 12));
            e_g.push_back(cfg_pseudo ? 0 : (cv[1] >> 12));
            e_b.push_back(cv[2] >> 12);
            e_cwe.push_back(int'(door));
            e_zwe.push_back(int'(door && pass));
            if (!cfg_z_hold) zv = (zv + dzv) & zmask;
            if (!cfg_c_hold) begin
                for (int c = 0; c < 3; c++) begin
                    cv[c] += sv[c];
                    if (cv[c] < 0) cv[c] = 0;
                    if (cv[c] > 20'hFFFFF) cv[c] = 20'hFFFFF;
                end
            end
        end
    endtask

    // one span: pulse start, then compare every cycle at the falling edge
    task automatic run_span(input string tag, input bit mid_start);
        int n;
        logic [12:0] saved;
        n = ($signed(span_count) > 0) ? int'($signed(span_count)) : 0;
        build_model(n);
        saved = span_count;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int j = 1; j <= n + 3; j++) begin
            bit eb, ev;
            eb = (n > 0) && (j <= n + 1);
            ev = (n > 0) && (j >= 2) && (j <= n + 1);
            check(busy === eb, {tag, " R1 R2"},
                  $sformatf("busy cycle %0d act=%0b exp=%0b", j, busy, eb));
            check(pix_valid === ev, {tag, " R2 R3"},
                  $sformatf("valid cycle %0d act=%0b exp=%0b", j, pix_valid, ev));
            if (!ev) begin
                check(pix_z_we === 1'b0 && pix_c_we === 1'b0, {tag, " R12"},
                      $sformatf("enables off-pixel act=%0b%0b exp=00", pix_z_we, pix_c_we));
            end else begin
                int k = j - 2;
                bit ok;
                ok = (int'(pix_addr) == e_addr[k]) && (int'(pix_z) == e_z[k])
                  && (int'(pix_red) == e_r[k]) && (int'(pix_green) == e_g[k])
                  && (int'(pix_blue) == e_b[k]) && (int'(pix_z_we) == e_zwe[k])
                  && (int'(pix_c_we) == e_cwe[k]);
                check(ok, tag, $sformatf(
                    "pixel %0d act a=%06h z=%06h rgb=%0d/%0d/%0d we=%0b%0b exp a=%06h z=%06h rgb=%0d/%0d/%0d we=%0d%0d",
                    k, pix_addr, pix_z, pix_red, pix_green, pix_blue, pix_z_we, pix_c_we,
                    e_addr[k], e_z[k], e_r[k], e_g[k], e_b[k], e_zwe[k], e_cwe[k]));
            end
            if (mid_start && j == 3) begin
                span_count = 13'd5;
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
        end
        span_count = saved;
    endtask

    task automatic reset_cfg();
        cfg_mask = 16'hFFFF; cfg_z_hold = 0; cfg_c_hold = 0; cfg_addr_hold = 0;
        cfg_pseudo = 0; cfg_z_wide = 0; cfg_cmp = 3'b100;
        red_init = 20'h40000; green_init = 20'h80800; blue_init = 20'h20000;
        red_step = 20'h00800; green_step = 20'hFFC00; blue_step = 20'h01000;
    endtask

    initial begin : watchdog
        #(200000 * 5);
        n_bad++;
        $display("FAIL R2 watchdog expired act=running exp=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        reset_cfg();
        repeat (4) @(negedge clk);
        check(busy === 1'b0 && pix_valid === 1'b0 && pix_z_we === 1'b0 && pix_c_we === 1'b0,
              "R13", $sformatf("in reset act=%0b%0b%0b%0b exp=0000",
              busy, pix_valid, pix_z_we, pix_c_we));
        rst_n = 1'b1;
        @(negedge clk);
        check(busy === 1'b0 && pix_valid === 1'b0 && pix_z_we === 1'b0 && pix_c_we === 1'b0,
              "R13", $sformatf("after reset act=%0b%0b%0b%0b exp=0000",
              busy, pix_valid, pix_z_we, pix_c_we));

        // R4: 16.12, garbage in ignored bits, less-than compare
        z_main = {16'h0010, 12'h800, 4'hF}; z_ext = 32'hDEADBEEF;
        dz_main = {16'h0000, 12'h400, 4'h9}; dz_ext = 32'hFFFFFFFF;
        gfx_addr = 24'h000010; span_count = 13'd20;
        run_span("R4 R6 R7", 1'b0);

        // R4: 16-bit Z wrap and address wrap, greater-than
        reset_cfg(); cfg_cmp = 3'b010;
        z_main = {16'hFFFE, 12'h000, 4'h0}; dz_main = {16'h0000, 12'hC00, 4'h0};
        gfx_addr = 24'hFFFFF8; span_count = 13'd24;
        run_span("R4 R11", 1'b0);

        // R5: 24.12 with extension fraction, eq|gt
        reset_cfg(); cfg_z_wide = 1; cfg_cmp = 3'b011;
        z_main = {24'h000100, 8'h00}; z_ext = {4'h8, 28'h1234567};
        dz_main = {24'h000000, 8'h80}; dz_ext = {4'h8, 28'h0};
        gfx_addr = 24'h000100; span_count = 13'd40;
        run_span("R5 R6", 1'b0);

        // R5: negative slope with large integer, all conditions enabled
        reset_cfg(); cfg_z_wide = 1; cfg_cmp = 3'b111;
        z_main = {24'h123456, 8'h10}; z_ext = '0;
        dz_main = 32'hFFFFFF00; dz_ext = {4'hC, 28'h0};
        gfx_addr = 24'h123450; span_count = 13'd10;
        run_span("R5 R6", 1'b0);

        // R8: saturation at both ends
        reset_cfg();
        red_init = 20'hFA000; red_step = 20'h03800;
        green_init = 20'h64800; green_step = 20'hFFC00;
        blue_init = 20'h05000; blue_step = 20'hFE000;
        z_main = '0; dz_main = '0; z_ext = '0; dz_ext = '0;
        gfx_addr = 24'h000200; span_count = 13'd30;
        run_span("R7 R8", 1'b0);

        // R9: pseudo-colour
        reset_cfg(); cfg_pseudo = 1;
        blue_init = 20'h10000; blue_step = 20'h02400;
        span_count = 13'd12;
        run_span("R9", 1'b0);

        // R10 / R11: holds; equal compare hits exactly one address
        reset_cfg(); cfg_z_hold = 1; cfg_c_hold = 1; cfg_z_wide = 1; cfg_cmp = 3'b001;
        z_main = {24'h000105, 8'h00}; dz_main = {24'h000003, 8'h00};
        gfx_addr = 24'h000100; span_count = 13'd12;
        run_span("R10 R6", 1'b0);
        cfg_addr_hold = 1; span_count = 13'd16;
        run_span("R10 R11", 1'b0);

        // R12: long span, irregular door pattern
        reset_cfg(); cfg_mask = 16'hA5C3; cfg_cmp = 3'b100;
        z_main = {16'h0000, 12'h000, 4'h0}; dz_main = {16'h0002, 12'h000, 4'h0};
        gfx_addr = 24'h000000; span_count = 13'd300;
        run_span("R12", 1'b0);

        // R1: counts of zero and below give no pixels
        reset_cfg();
        span_count = 13'd0;      run_span("R1", 1'b0);
        span_count = 13'h1FFF;   run_span("R1", 1'b0);
        span_count = 13'h1000;   run_span("R1", 1'b0);

        // R2: single pixel
        span_count = 13'd1; gfx_addr = 24'h0000AA;
        run_span("R2", 1'b0);

        // R3: start during a span is ignored
        span_count = 13'd8;
        run_span("R3", 1'b1);
        span_count = 13'd3;
        run_span("R3", 1'b1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule